// File: doc/BRIEF.md
# Redundant Synchronizer Selection Controller

This controller manages a bank of identical two-flop synchronizers that all sample the same asynchronous signal. Process spread means some copies resolve metastability more slowly than others. After a start pulse at chip setup, the controller measures the copies one at a time through a single shared failure-counting path. Each copy is observed over the same fixed number of receiver clock cycles. At the end of each window, the late-failure count for that copy is pushed into a small FIFO.

Once every copy has been measured, the controller pops the FIFO entries in measurement order and keeps the smallest count. It then does four things:
- routes the winning copy's output to the consumer;
- keeps power only on that copy;
- switches off its own measurement logic;
- raises a done flag.

The choice is made once and then holds until the next reset. The controller uses no cycle-count ratio. It compares only the raw failure counts.

Top module: `sync_select_ctrl`

## Requirements
- R1: While reset is asserted and after its release until selection completes, `done` is 0, `selIdx` is 0, `outSel` is 4'b0001, every bit of `powerEn` is 1 and `measPowerEn` is 1.
- R2: Copies are measured in index order 0,1,2,3. Take the rising edge that samples `start` high as edge 0. The window of copy k then covers edges k*W+1 through (k+1)*W, where W is `WINDOW_CYCLES`. Only `failStrobe[k]` sampled at those edges adds to copy k's count. The strobes of the other copies are ignored during that window.
- R3: The copy with the smallest late-failure count is selected.
- R4: When several copies share the smallest count, the lowest index among them is selected.
- R5: `done` is 0 after edge N*W+N-1 and is 1 after edge N*W+N, where N is the number of copies (4).
- R6: Once `done` is 1, `powerEn` is one-hot with its set bit at `selIdx`, and `measPowerEn` is 0.
- R7: `outSel` is always one-hot at bit `selIdx`, and `dataOut` always equals `syncIn[selIdx]`.
- R8: After `done` rises, `done`, `selIdx` and `powerEn` hold until reset. A later `start` pulse does not start a new selection.
- R9: A `start` pulse while a measurement is running changes neither the counts nor the completion time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins the one-time selection when idle |
| failStrobe | input | 4 | Per-copy late-failure strobe, one bit per synchronizer |
| syncIn | input | 4 | Outputs of the synchronizer copies |
| powerEn | output | 4 | Power enable per synchronizer copy |
| measPowerEn | output | 1 | Power enable for the measurement and selection logic |
| selIdx | output | 2 | Index of the chosen copy |
| outSel | output | 4 | One-hot output select |
| dataOut | output | 1 | Routed output of the selected copy |
| done | output | 1 | Selection complete |

## Verification
A strobe sampled at edge n belongs to copy (n-1)/W. The bench therefore drives each strobe on the falling edge before edge n and computes the expected counts from that mapping. `done`, `selIdx`, `powerEn`, `measPowerEn` and `outSel` all change together, on the edge that pops the last FIFO entry. That is N*W+N edges after the edge that sampled start. The bench counts edges and samples 1 ns after edges N*W+N-1 and N*W+N. The routed `dataOut` is combinational from `syncIn`, so it is checked 1 ns after each new `syncIn` value. Stability and the ignored restart are checked 2*W cycles after a further start pulse.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MEASURE,
    ST_COMPARE,
    ST_DONE
  } selState_t;

  typedef struct packed {
    logic countEn;    // accumulate the shared failure sample
    logic endWindow;  // last cycle of a window: push the count
    logic pop;        // compare phase: pop one FIFO entry
    logic firstPop;   // first pop: load the running minimum
  } ctlStrobe_t;

endpackage

// File: rtl/ssc_control.sv
module ssc_control
  import ssc_pkg::*;
#(
  parameter int NUM_SYNC      = 4,
  parameter int WINDOW_CYCLES = 64
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  output ctlStrobe_t                  strobes,
  output logic [$clog2(NUM_SYNC)-1:0] curIdx,
  output logic                        selDone
);

  localparam int IDX_W = $clog2(NUM_SYNC);
  localparam int WIN_W = $clog2(WINDOW_CYCLES);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW_CYCLES - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_SYNC - 1);

  selState_t        state;
  logic [IDX_W-1:0] idx;
  logic [WIN_W-1:0] winCnt;
  logic             lastWinCycle;

  assign lastWinCycle = (winCnt == WIN_LAST);

  always_comb begin
    strobes           = '0;
    strobes.countEn   = (state == ST_MEASURE);
    strobes.endWindow = (state == ST_MEASURE) && lastWinCycle;
    strobes.pop       = (state == ST_COMPARE);
    strobes.firstPop  = (state == ST_COMPARE) && (idx == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      idx    <= '0;
      winCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_MEASURE;
            idx    <= '0;
            winCnt <= '0;
          end
        end
        ST_MEASURE: begin
          if (lastWinCycle) begin
            winCnt <= '0;
            if (idx == IDX_LAST) begin
              state <= ST_COMPARE;
              idx   <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            winCnt <= winCnt + 1'b1;
          end
        end
        ST_COMPARE: begin
          if (idx == IDX_LAST) begin
            state <= ST_DONE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: begin
          state <= ST_DONE;
        end
      endcase
    end
  end

  assign curIdx  = idx;
  assign selDone = (state == ST_DONE);

endmodule

// File: rtl/ssc_datapath.sv
module ssc_datapath
  import ssc_pkg::*;
#(
  parameter int NUM_SYNC = 4,
  parameter int CNT_W    = 7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctlStrobe_t                  strobes,
  input  logic [$clog2(NUM_SYNC)-1:0] curIdx,
  input  logic [NUM_SYNC-1:0]         failStrobe,
  output logic [$clog2(NUM_SYNC)-1:0] bestIdx
);

  localparam int IDX_W = $clog2(NUM_SYNC);
  localparam logic [IDX_W-1:0] PTR_LAST = IDX_W'(NUM_SYNC - 1);

  logic             sharedSample;
  logic [CNT_W-1:0] failCnt;
  logic [CNT_W-1:0] nextCnt;
  logic [CNT_W-1:0] fifoMem [NUM_SYNC];
  logic [IDX_W-1:0] wrPtr;
  logic [IDX_W-1:0] rdPtr;
  logic [CNT_W-1:0] headCnt;
  logic [CNT_W-1:0] bestCnt;
  logic             takeHead;

  // Single measurement path: only the copy under test reaches the counter.
  assign sharedSample = failStrobe[curIdx];
  assign nextCnt      = failCnt + CNT_W'(sharedSample);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failCnt <= '0;
    end else if (strobes.countEn) begin
      failCnt <= strobes.endWindow ? '0 : nextCnt;
    end
  end

  // Count FIFO, one entry per copy, written in measurement order.
  for (genvar e = 0; e < NUM_SYNC; e++) begin : g_fifo
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fifoMem[e] <= '0;
      end else if (strobes.endWindow && (wrPtr == IDX_W'(e))) begin
        fifoMem[e] <= nextCnt;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.endWindow) begin
        wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      end
      if (strobes.pop) begin
        rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      end
    end
  end

  assign headCnt  = fifoMem[rdPtr];
  // Strict less-than keeps the earlier (lower) index on a tie.
  assign takeHead = strobes.pop && (strobes.firstPop || (headCnt < bestCnt));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bestCnt <= '0;
      bestIdx <= '0;
    end else if (takeHead) begin
      bestCnt <= headCnt;
      bestIdx <= curIdx;
    end
  end

endmodule

// File: rtl/sync_select_ctrl.sv
module sync_select_ctrl
  import ssc_pkg::*;
#(
  parameter int NUM_SYNC      = 4,
  parameter int WINDOW_CYCLES = 64
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [NUM_SYNC-1:0]         failStrobe,
  input  logic [NUM_SYNC-1:0]         syncIn,
  output logic [NUM_SYNC-1:0]         powerEn,
  output logic                        measPowerEn,
  output logic [$clog2(NUM_SYNC)-1:0] selIdx,
  output logic [NUM_SYNC-1:0]         outSel,
  output logic                        dataOut,
  output logic                        done
);

  localparam int IDX_W = $clog2(NUM_SYNC);
  localparam int CNT_W = $clog2(WINDOW_CYCLES + 1);

  ctlStrobe_t       strobes;
  logic [IDX_W-1:0] curIdx;
  logic [IDX_W-1:0] bestIdx;
  logic             selDone;

  ssc_control #(
    .NUM_SYNC      (NUM_SYNC),
    .WINDOW_CYCLES (WINDOW_CYCLES)
  ) u_control (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobes (strobes),
    .curIdx  (curIdx),
    .selDone (selDone)
  );

  ssc_datapath #(
    .NUM_SYNC (NUM_SYNC),
    .CNT_W    (CNT_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .curIdx     (curIdx),
    .failStrobe (failStrobe),
    .bestIdx    (bestIdx)
  );

  assign done        = selDone;
  assign selIdx      = selDone ? bestIdx : '0;
  assign measPowerEn = !selDone;
  assign dataOut     = syncIn[selIdx];

  for (genvar s = 0; s < NUM_SYNC; s++) begin : g_route
    assign outSel[s]  = (selIdx == IDX_W'(s));
    assign powerEn[s] = selDone ? (bestIdx == IDX_W'(s)) : 1'b1;
  end

endmodule

// File: rtl/ssc_checker.sv
module ssc_checker #(
  parameter int NUM_SYNC = 4
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [NUM_SYNC-1:0]         powerEn,
  input logic                        measPowerEn,
  input logic [$clog2(NUM_SYNC)-1:0] selIdx,
  input logic [NUM_SYNC-1:0]         outSel,
  input logic                        done
);

  // R1: before selection every copy and the measurement logic stay powered
  a_r1_all_powered: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> (&powerEn) && measPowerEn);

  // R6: exactly the selected copy keeps power after selection
  a_r6_single_power: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($countones(powerEn) == 1) && powerEn[selIdx]);

  // R6: measurement logic off after selection
  a_r6_meas_off: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !measPowerEn);

  // R7: output select agrees with the selected index
  a_r7_outsel_match: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(outSel) == 1) && outSel[selIdx]);

  // R8: selection holds once made
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done && $stable(selIdx) && $stable(powerEn));

endmodule

bind sync_select_ctrl ssc_checker #(.NUM_SYNC(NUM_SYNC)) u_ssc_checker (
  .clk         (clk),
  .rstN        (rstN),
  .powerEn     (powerEn),
  .measPowerEn (measPowerEn),
  .selIdx      (selIdx),
  .outSel      (outSel),
  .done        (done)
);

// File: tb/sync_select_ctrl_bench.sv
`timescale 1ns/1ps
module sync_select_ctrl_bench;

  localparam int N = 4;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] failStrobe = '0;
  logic [N-1:0] syncIn = '0;
  logic [N-1:0] powerEn;
  logic         measPowerEn;
  logic [1:0]   selIdx;
  logic [N-1:0] outSel;
  logic         dataOut;
  logic         done;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sync_select_ctrl #(.NUM_SYNC(N), .WINDOW_CYCLES(W)) u_sync_select_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .failStrobe(failStrobe),
    .syncIn(syncIn), .powerEn(powerEn), .measPowerEn(measPowerEn),
    .selIdx(selIdx), .outSel(outSel), .dataOut(dataOut), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(1'b0, "watchdog", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic runCase(input int c0, input int c1, input int c2, input int c3);
    int cnt [N];
    int best;
    cnt[0] = c0; cnt[1] = c1; cnt[2] = c2; cnt[3] = c3;
    best = 0;
    for (int k = 1; k < N; k++) if (cnt[k] < cnt[best]) best = k;  // R3, R4

    rstN = 1'b0; start = 1'b0; failStrobe = '0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rstN = 1'b1; #1;
    // R1 reset state
    chk(done == 1'b0 && selIdx == 2'd0 && outSel == 4'b0001, "R1 idle outputs",
        int'({done, selIdx, outSel}), 1);
    chk(powerEn == 4'b1111 && measPowerEn == 1'b1, "R1 power",
        int'({powerEn, measPowerEn}), 31);

    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    for (int n = 1; n <= N * W + N; n++) begin
      if (n > 1) @(negedge clk);
      start = (n == W + 2);  // R9: restart mid-measurement must be ignored
      if (n <= N * W) begin
        int k = (n - 1) / W;
        int j = (n - 1) % W;
        // R2: foreign strobes held high, own strobe high for cnt[k] cycles
        failStrobe = ~(N'(1) << k);
        if (j < cnt[k]) failStrobe[k] = 1'b1;
      end else begin
        failStrobe = '1;
      end
      @(posedge clk); #1;
      if (n == N * W + N - 1) chk(done == 1'b0, "R5 done not early", int'(done), 0);
      if (n == N * W + N)     chk(done == 1'b1, "R5 done on time", int'(done), 1);
    end
    chk(int'(selIdx) == best, "R3 R4 R2 selected index", int'(selIdx), best);
    chk(powerEn == (N'(1) << best), "R6 power enables", int'(powerEn), 1 << best);
    chk(measPowerEn == 1'b0, "R6 measurement off", int'(measPowerEn), 0);
    chk(outSel == (N'(1) << best), "R7 output select", int'(outSel), 1 << best);
    for (int v = 0; v < 16; v++) begin
      syncIn = N'(v); #1;
      chk(dataOut == syncIn[best], "R7 routed data", int'(dataOut), int'(syncIn[best]));
    end
    // R8: a second start must not rerun the selection
    @(negedge clk); start = 1'b1; failStrobe = '0;
    @(negedge clk); start = 1'b0;
    for (int m = 0; m < 2 * W; m++) begin
      failStrobe = N'(m);
      @(negedge clk);
    end
    chk(done == 1'b1 && int'(selIdx) == best, "R8 selection held",
        int'(selIdx), best);
    chk(powerEn == (N'(1) << best), "R8 power held", int'(powerEn), 1 << best);
  endtask

  initial begin
    int vals [3];
    vals[0] = 0; vals[1] = 2; vals[2] = W;
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++)
          for (int d = 0; d < 3; d++)
            runCase(vals[a], vals[b], vals[c], vals[d]);
    runCase(5, 4, 3, 1);
    runCase(W, W, W, W);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule